// File: doc/BRIEF.md
# Parallel QPP Interleaver Address Generator

This block produces the interleaved memory addresses for an eight-lane parallel turbo decoder. For a block of length K the quadratic permutation is pi(x) = (f1·x + f2·x²) mod K. Lane j walks the index x = i + j·M, where M = K/8 and i runs from 0 to M−1. On every beat, each lane gives its address split into a bank index (pi / M) and an offset inside that bank (pi mod M). The eight bank indices of one beat never repeat, so they can steer a plain permutation network without collisions.

Software or a controller supplies K, f1 and f2 and pulses `start`. The block first checks K. It then runs a setup phase that walks the permutation once to find each lane's starting address and increment. After that it streams M beats. Every lane value comes from modular additions only; no multiplier is used.

The output is a valid/ready stream. A beat is taken on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current beat stays on the outputs unchanged. Lowering `out_ready` never drops a beat and never skips one.

Top module: `qpp_addr_gen`

## Requirements
- R1: A `start` pulse taken in idle with K not a multiple of 8, below 40 or above 6144 sets `err` on the next cycle. The block stays idle with `out_valid` low. A later `start` with a legal K clears `err`.
- R2: On beat i, lane j delivers pi(i + j·M) = (f1·x + f2·x²) mod K with x = i + j·M, assuming f1 < K and f2 < K.
- R3: Lane j's address is the field `out_bank[3j+2:3j]` = pi div M together with the field `out_off[10j+9:10j]` = pi mod M. The offset is always below M.
- R4: On every valid beat the eight bank indices are all different, so together they form a permutation of 0..7.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bank` and `out_off` keep their values on the next cycle.
- R6: `out_last` is high exactly on beat i = M−1. After that beat is accepted, `out_valid` and `busy` are low on the next cycle.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The stream in progress keeps the K, f1 and f2 it started with.
- R8: After a legal `start`, `busy` rises and `out_valid` stays low for the whole setup phase. Beat 0 then appears with no gap in the setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a block |
| blk_len | input | 13 | Block length K |
| coef_a | input | 13 | Linear coefficient f1 |
| coef_b | input | 13 | Quadratic coefficient f2 |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | Beat on the outputs is valid |
| out_last | output | 1 | Current beat is the final one of the block |
| out_bank | output | 24 | Eight 3-bit bank indices, lane 0 in the low bits |
| out_off | output | 80 | Eight 10-bit in-bank offsets, lane 0 in the low bits |
| busy | output | 1 | Setup or streaming in progress |
| err | output | 1 | Last requested block length was rejected |

## Verification
Two events can land on the same cycle.

The first pair is a stall and the final beat. With random back-pressure, a block's last beat is often held for several cycles. The bench then checks that `out_last` and the addresses stay fixed until the beat is accepted, and that the stream drops on the cycle right after.

The second pair is a new `start` and active streaming. During the run the bench raises `start` with a different legal K. It then checks that every later beat still matches a direct evaluation of the original polynomial, and that the bank indices of each beat remain a permutation.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  localparam int QPP_LANES = 8;
  localparam int QPP_KW    = 13;
  localparam int QPP_OFFW  = 10;
  localparam int QPP_KMIN  = 40;
  localparam int QPP_KMAX  = 6144;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PREP  = 2'd1,
    ST_SETUP = 2'd2,
    ST_RUN   = 2'd3
  } qpp_state_t;
endpackage

// File: rtl/qpp_modadd.sv
module qpp_modadd #(
  parameter int W = 13
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] k,
  output logic [W-1:0] s
);
  logic [W:0] sum;
  logic [W:0] kx;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    kx  = {1'b0, k};
    if (sum >= kx) s = W'(sum - kx);
    else           s = W'(sum);
  end
endmodule

// File: rtl/qpp_walker.sv
module qpp_walker #(
  parameter int LANES = 8,
  parameter int KW    = 13,
  parameter int OFFW  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [KW-1:0]    k,
  input  logic [KW-1:0]    g0,
  input  logic [KW-1:0]    step2,
  input  logic [KW-1:0]    m,
  output logic [LANES-1:0] cap,
  output logic [KW-1:0]    w_pi,
  output logic [KW-1:0]    w_g,
  output logic             done
);
  localparam int BW = $clog2(LANES);

  logic            active;
  logic [BW-1:0]   lane;
  logic [OFFW-1:0] sub;
  logic [KW-1:0]   nxt_pi, nxt_g;
  logic            sub_wrap;

  qpp_modadd #(.W(KW)) u_pi (.a(w_pi), .b(w_g),   .k(k), .s(nxt_pi));
  qpp_modadd #(.W(KW)) u_g  (.a(w_g),  .b(step2), .k(k), .s(nxt_g));

  assign sub_wrap = (KW'(sub) == m - KW'(1));
  assign done     = active && (sub == '0) && (lane == BW'(LANES - 1));

  always_comb begin
    cap = '0;
    if (active && sub == '0) cap[lane] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      lane   <= '0;
      sub    <= '0;
      w_pi   <= '0;
      w_g    <= '0;
    end else if (go) begin
      active <= 1'b1;
      lane   <= '0;
      sub    <= '0;
      w_pi   <= '0;
      w_g    <= g0;
    end else if (active) begin
      if (done) begin
        active <= 1'b0;
      end else begin
        w_pi <= nxt_pi;
        w_g  <= nxt_g;
        if (sub_wrap) begin
          sub  <= '0;
          lane <= lane + BW'(1);
        end else begin
          sub <= sub + OFFW'(1);
        end
      end
    end
  end

  p_walk_below_k_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (w_pi < k) && (w_g < k));
endmodule

// File: rtl/qpp_lane.sv
module qpp_lane #(
  parameter int LANES = 8,
  parameter int KW    = 13,
  parameter int OFFW  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [KW-1:0]           ld_pi,
  input  logic [KW-1:0]           ld_g,
  input  logic                    adv,
  input  logic                    vld,
  input  logic [KW-1:0]           k,
  input  logic [KW-1:0]           step2,
  input  logic [KW-1:0]           m,
  input  logic [LANES*KW-1:0]     thr,
  output logic [$clog2(LANES)-1:0] bank,
  output logic [OFFW-1:0]         off
);
  localparam int BW = $clog2(LANES);

  logic [KW-1:0] pi_q, g_q, nxt_pi, nxt_g, base;

  qpp_modadd #(.W(KW)) u_pi (.a(pi_q), .b(g_q),   .k(k), .s(nxt_pi));
  qpp_modadd #(.W(KW)) u_g  (.a(g_q),  .b(step2), .k(k), .s(nxt_g));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi_q <= '0;
      g_q  <= '0;
    end else if (load) begin
      pi_q <= ld_pi;
      g_q  <= ld_g;
    end else if (adv) begin
      pi_q <= nxt_pi;
      g_q  <= nxt_g;
    end
  end

  always_comb begin
    bank = '0;
    base = '0;
    for (int b = 1; b < LANES; b++) begin
      if (pi_q >= thr[b*KW +: KW]) begin
        bank = BW'(b);
        base = thr[b*KW +: KW];
      end
    end
    off = OFFW'(pi_q - base);
  end

  p_off_below_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (KW'(off) < m) && (pi_q < k));
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int LANES = QPP_LANES,
  parameter int KW    = QPP_KW,
  parameter int OFFW  = QPP_OFFW,
  parameter int KMIN  = QPP_KMIN,
  parameter int KMAX  = QPP_KMAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [KW-1:0]           blk_len,
  input  logic [KW-1:0]           coef_a,
  input  logic [KW-1:0]           coef_b,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic                    out_last,
  output logic [LANES*$clog2(LANES)-1:0] out_bank,
  output logic [LANES*OFFW-1:0]   out_off,
  output logic                    busy,
  output logic                    err
);
  localparam int BW = $clog2(LANES);

  qpp_state_t      st;
  logic [KW-1:0]   k_q, fa_q, fb_q;
  logic [OFFW-1:0] icnt;
  logic [KW-1:0]   m_w, g0, step2;
  logic [LANES*KW-1:0] thr;
  logic            k_ok, hs, go, walk_done;
  logic [LANES-1:0] cap;
  logic [KW-1:0]   w_pi, w_g;
  logic [LANES-1:0] bank_mask;

  assign m_w  = k_q >> BW;
  assign k_ok = (blk_len[BW-1:0] == '0) && (blk_len >= KW'(KMIN)) &&
                (blk_len <= KW'(KMAX));
  assign out_valid = (st == ST_RUN);
  assign busy      = (st != ST_IDLE);
  assign hs        = out_valid && out_ready;
  assign out_last  = out_valid && (KW'(icnt) == m_w - KW'(1));
  assign go        = (st == ST_PREP);

  qpp_modadd #(.W(KW)) u_g0 (.a(fa_q), .b(fb_q), .k(k_q), .s(g0));
  qpp_modadd #(.W(KW)) u_s2 (.a(fb_q), .b(fb_q), .k(k_q), .s(step2));

  for (genvar j = 0; j < LANES; j++) begin : g_thr
    assign thr[j*KW +: KW] = KW'(m_w * KW'(j));
  end

  qpp_walker #(.LANES(LANES), .KW(KW), .OFFW(OFFW)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .k(k_q), .g0(g0), .step2(step2),
    .m(m_w), .cap(cap), .w_pi(w_pi), .w_g(w_g), .done(walk_done)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    qpp_lane #(.LANES(LANES), .KW(KW), .OFFW(OFFW)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(cap[j]), .ld_pi(w_pi), .ld_g(w_g),
      .adv(hs), .vld(out_valid), .k(k_q), .step2(step2), .m(m_w), .thr(thr),
      .bank(out_bank[j*BW +: BW]), .off(out_off[j*OFFW +: OFFW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      k_q  <= '0;
      fa_q <= '0;
      fb_q <= '0;
      icnt <= '0;
      err  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          if (k_ok) begin
            err  <= 1'b0;
            k_q  <= blk_len;
            fa_q <= coef_a;
            fb_q <= coef_b;
            st   <= ST_PREP;
          end else begin
            err <= 1'b1;
          end
        end
        ST_PREP:  st <= ST_SETUP;
        ST_SETUP: if (walk_done) begin
          icnt <= '0;
          st   <= ST_RUN;
        end
        ST_RUN: if (hs) begin
          if (out_last) st <= ST_IDLE;
          else          icnt <= icnt + OFFW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bank_mask = '0;
    for (int j = 0; j < LANES; j++) bank_mask[out_bank[j*BW +: BW]] = 1'b1;
  end

  p_err_novalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);
  p_banks_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(bank_mask) == LANES));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_bank) && $stable(out_off));
  p_last_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_last) |=> !out_valid && !busy);
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(k_q) && $stable(fa_q) && $stable(fb_q));
endmodule

// File: tb/sim_qpp_addr_gen.sv
module sim_qpp_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [12:0] blk_len = '0, coef_a = '0, coef_b = '0;
  logic out_ready = 1'b0;
  logic out_valid, out_last, busy, err;
  logic [23:0] out_bank;
  logic [79:0] out_off;
  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  qpp_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .coef_a(coef_a), .coef_b(coef_b), .out_ready(out_ready),
    .out_valid(out_valid), .out_last(out_last), .out_bank(out_bank),
    .out_off(out_off), .busy(busy), .err(err)
  );

  function automatic longint ref_pi(longint kk, longint f1, longint f2, longint x);
    return (f1 * x + f2 * x * x) % kk;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bad_k(input int kk);
    @(negedge clk);
    blk_len = 13'(kk); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R1 err set", err, 1);
    chk(!out_valid && !busy, "R1 stays idle", {busy, out_valid}, 0);
  endtask

  task automatic run_blk(input int kk, input int f1, input int f2, input bit poke);
    int m = kk / 8;
    int i = 0;
    int guard = 0;
    bit stalled = 1'b0;
    bit rdy;
    logic [23:0] sb;
    logic [79:0] so;
    @(negedge clk);
    blk_len = 13'(kk); coef_a = 13'(f1); coef_b = 13'(f2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !out_valid, "R8 setup busy no valid", {busy, out_valid}, 2);
    chk(err == 1'b0, "R1 err cleared", err, 0);
    while (!out_valid && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (!out_valid && !busy) break;
    end
    chk(out_valid, "R8 valid after setup", out_valid, 1);
    while (i < m && out_valid) begin
      bit lanes_ok = 1'b1;
      logic [7:0] seen = '0;
      longint bad_a = 0, bad_e = 0;
      if (stalled) chk(out_bank == sb && out_off == so, "R5 held under stall", out_off, so);
      for (int j = 0; j < 8; j++) begin
        longint e = ref_pi(kk, f1, f2, i + j * m);
        longint eb = e / m;
        longint eo = e % m;
        longint ab = out_bank[j*3 +: 3];
        longint ao = out_off[j*10 +: 10];
        seen[out_bank[j*3 +: 3]] = 1'b1;
        if (ab != eb || ao != eo) begin
          lanes_ok = 1'b0; bad_a = ab * m + ao; bad_e = e;
        end
      end
      chk(lanes_ok, "R2 R3 lane address", bad_a, bad_e);
      chk(seen == 8'hFF, "R4 bank permutation", seen, 8'hFF);
      chk(out_last == (i == m - 1), "R6 last flag", out_last, i == m - 1);
      if (poke && i == 1) begin
        blk_len = 13'd40; coef_a = 13'd3; coef_b = 13'd10; start = 1'b1;
      end
      rdy = (($urandom % 4) != 0);
      out_ready = rdy;
      stalled = !rdy; sb = out_bank; so = out_off;
      @(negedge clk);
      start = 1'b0;
      if (rdy) i++;
    end
    out_ready = 1'b0;
    chk(i == m, "R7 full block delivered", i, m);
    chk(!out_valid && !busy, "R6 drop after last", {busy, out_valid}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy && !err, "R1 reset state", {out_valid, busy, err}, 0);
    bad_k(44);
    run_blk(40, 3, 10, 1'b0);
    bad_k(32);
    bad_k(6152);
    run_blk(64, 7, 16, 1'b1);
    run_blk(104, 7, 26, 1'b0);
    run_blk(1024, 31, 64, 1'b1);
    run_blk(6144, 263, 480, 1'b0);
    run_blk(40, 3, 10, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule